// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block guards a small processor against runaway code. A free-running prescaler divides the system clock. A tap chosen by software feeds a two-bit overflow counter. When that counter wraps, the block issues a one-cycle pulse. The pulse goes to the reset sequencer or to the interrupt controller, as a routing bit selects. The watchdog runs from the moment reset is released and needs no enable step.

Software reaches two 8-bit registers through a write-only port. The setup register at address 0 holds the timeout select and the routing bit. Writing the key value to the service register at address 1 empties the overflow counter. The key leaves the prescaler alone, so the time left after a service depends on the prescaler's phase. It can shrink to three quarters of the nominal period, and firmware must service more often than that. A low-power input freezes the prescaler and the counter in place. Both resume from the held values when the input drops.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the timeout select is 0, the routing bit is 1 (reset request), both outputs are low, and counting begins at the first clock after reset is released.
- R2: Without service, overflow pulses appear every 2^(TAP_BASE+8-2*sel) clock cycles, where sel is the 2-bit timeout select. With the default TAP_BASE of 17 this gives 2^25, 2^23, 2^21 and 2^19 cycles for sel 0 to 3.
- R3: Writing 0x4E to address 1 clears the overflow counter to zero and does not disturb the prescaler. This is true even when the write lands on a prescaler tap.
- R4: Writing any other value to address 1 leaves the counter and the overflow timing unchanged.
- R5: If software services at intervals shorter than three quarters of the selected period, no overflow pulse ever occurs.
- R6: An overflow raises a one-cycle pulse on exactly one output: `wdt_rst_req` when the routing bit is 1, `wdt_irq` when it is 0. The pulse is registered and appears in the cycle after the overflowing tick.
- R7: While `lp_hold` is high, neither the prescaler nor the counter advances. After `lp_hold` drops, counting continues from the held values.
- R8: After each overflow the counter restarts from zero, so overflows repeat at the period while service is absent.
- R9: A write to address 0 loads the timeout select from data bits [1:0] and the routing bit from data bit [2]. Bits [7:3] are ignored. The new setting acts from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_hold | input | 1 | High during stop, idle or sleep; freezes counting |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = setup register, 1 = service register |
| wr_data | input | 8 | Write data |
| wdt_rst_req | output | 1 | One-cycle reset request on overflow |
| wdt_irq | output | 1 | One-cycle interrupt request on overflow |

## Verification
The counter and the prescaler are both hidden. A corrupted value shows at the ports only as an overflow pulse that comes too early, too late, or not at all. A wrong counter value therefore becomes visible within one period at most. A prescaler fault stays hidden until its next tap. The bench models the timer cycle by cycle and compares both outputs on every clock. Any timing slip is caught on the exact cycle where a pulse should or should not appear. This covers the short service interval, rejected keys, routing changes and holds that end mid-period.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int TAP_BASE = 17,
  parameter logic [7:0] CLEAR_KEY = 8'h4E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lp_hold,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  output logic       wdt_rst_req,
  output logic       wdt_irq
);
  localparam int PW = TAP_BASE + 6;

  logic [PW-1:0] pre;
  logic [1:0]    cnt;
  logic [1:0]    tsel;
  logic          route_rst;
  logic [PW-1:0] mask;
  logic          tick, key_hit, ovf;

  always_comb begin
    mask = '1;
    for (int s = 0; s < 4; s++)
      if (tsel == 2'(s)) mask = PW'((64'd1 << (TAP_BASE + 6 - 2*s)) - 64'd1);
  end

  assign tick    = !lp_hold && ((pre & mask) == mask);
  assign key_hit = wr_en && wr_addr && (wr_data == CLEAR_KEY);
  assign ovf     = tick && (cnt == 2'd3) && !key_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre         <= '0;
      cnt         <= '0;
      tsel        <= 2'd0;
      route_rst   <= 1'b1;
      wdt_rst_req <= 1'b0;
      wdt_irq     <= 1'b0;
    end else begin
      if (!lp_hold) pre <= pre + 1'b1;
      if (key_hit)   cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
      if (wr_en && !wr_addr) begin
        tsel      <= wr_data[1:0];
        route_rst <= wr_data[2];
      end
      wdt_rst_req <= ovf && route_rst;
      wdt_irq     <= ovf && !route_rst;
    end
  end

  assert_pulse_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wdt_rst_req && wdt_irq));
  assert_rst_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |=> !wdt_rst_req);
  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_irq |=> !wdt_irq);
  assert_hold_pre_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lp_hold |=> $stable(pre));
  assert_hold_cnt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_hold && !key_hit) |=> $stable(cnt));
  assert_key_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |=> (cnt == 2'd0));
  assert_key_keeps_pre_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_hit && !lp_hold) |=> (pre == $past(pre) + 1'b1));
  assert_bad_key_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr && !key_hit && !tick) |=> $stable(cnt));
  assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt == 2'd0));
endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb_top;
  localparam int TAP = 3;
  logic clk = 1'b0;
  logic rst_n = 1'b0, lp_hold = 1'b0, wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic wdt_rst_req, wdt_irq;
  int compared = 0, mismatched = 0, cycles = 0;
  int rst_seen = 0, irq_seen = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  keyed_watchdog #(.TAP_BASE(TAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .lp_hold(lp_hold), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .wdt_rst_req(wdt_rst_req), .wdt_irq(wdt_irq));

  longint m_pre;
  int m_cnt, m_sel;
  bit m_route, exp_rst, exp_irq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_sel = 0; m_route = 1; exp_rst = 0; exp_irq = 0;
    end else begin
      longint span;
      bit tk, key, ov;
      span = longint'(1) << (TAP + 6 - 2*m_sel);
      tk  = !lp_hold && ((m_pre % span) == span - 1);
      key = wr_en && wr_addr && wr_data == 8'h4E;
      ov  = tk && m_cnt == 3 && !key;
      exp_rst = ov && m_route;
      exp_irq = ov && !m_route;
      if (key) m_cnt = 0; else if (tk) m_cnt = (m_cnt + 1) % 4;
      if (!lp_hold) m_pre = m_pre + 1;
      if (wr_en && !wr_addr) begin m_sel = wr_data[1:0]; m_route = wr_data[2]; end
    end
  end

  task automatic check(string req, int act, int expv);
    compared++;
    if (act != expv) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(cur_req, {wdt_rst_req, wdt_irq}, {exp_rst, exp_irq});
      rst_seen += wdt_rst_req;
      irq_seen += wdt_irq;
    end
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic wr(bit a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic zero_seen();
    rst_seen = 0; irq_seen = 0;
  endtask

  initial begin
    idle(3);
    check("R1", {wdt_rst_req, wdt_irq}, 0);
    rst_n = 1'b1;
    cur_req = "R2";
    zero_seen();
    idle(2100);
    check("R1 R2 free run rst pulses", rst_seen, 1);
    check("R1 R6 no irq while routed to reset", irq_seen, 0);

    cur_req = "R9";
    wr(1'b1, 8'h4E);
    wr(1'b0, 8'hFB);
    zero_seen();
    idle(100);
    check("R9 R8 repeated irq pulses sel3", irq_seen, 3);
    check("R6 no rst when routed to irq", rst_seen, 0);

    cur_req = "R5";
    zero_seen();
    for (int k = 0; k < 90; k++) begin
      wr(1'b1, 8'h4E);
      idle(22);
    end
    check("R5 no overflow under 3/4 service", rst_seen + irq_seen, 0);

    cur_req = "R4";
    zero_seen();
    for (int k = 0; k < 9; k++) begin
      wr(1'b1, (k % 2) ? 8'h4F : 8'h00);
      idle(22);
    end
    check("R4 bad keys do not service", irq_seen >= 6, 1);

    cur_req = "R7";
    wr(1'b1, 8'h4E);
    idle(10);
    lp_hold = 1'b1;
    zero_seen();
    idle(300);
    check("R7 no pulse while held", rst_seen + irq_seen, 0);
    lp_hold = 1'b0;
    zero_seen();
    idle(40);
    check("R7 resumes after hold", irq_seen >= 1, 1);

    cur_req = "R2";
    wr(1'b0, 8'h05);
    wr(1'b1, 8'h4E);
    zero_seen();
    idle(520);
    check("R2 sel1 period 512 reset route", rst_seen, 1);
    wr(1'b0, 8'h02);
    wr(1'b1, 8'h4E);
    zero_seen();
    idle(260);
    check("R2 sel2 period 128 irq route", irq_seen, 2);

    cur_req = "R3";
    wr(1'b0, 8'h03);
    for (int k = 0; k < 40; k++) begin
      wr(1'b1, 8'h4E);
      idle(k % 7);
    end
    idle(70);
    cur_req = "R6";
    wr(1'b0, 8'h07);
    idle(70);
    check("R6 R8 compared cycles", compared > 3000, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule